// File: doc/BRIEF.md
# Transmit Cell Port Interrupt Register Block

This block is the processor-facing interrupt control for a transmit cell port. Three event sources feed it with single-cycle pulses: a parity error on incoming cell data, a change of cell alignment (for example a short cell), and an overrun of the transmit FIFO. Each pulse is caught in a sticky status flag. The flag stays set until the processor reads the port's local register. A read of that register returns the flags and clears them in the same access.

Each source has its own enable in the local register. A flag whose enable is set contributes to one summary bit. That bit appears in a separate device-level interrupt status register and also drives an active-low interrupt output. The local register also holds a discard-on-parity-error control and a self-clearing FIFO reset command. The FIFO reset produces a one-cycle pulse towards the FIFO.

The register bus is a simple synchronous strobe interface. The read data is combinational from the address during a read strobe. Clear-on-read takes effect at the clock edge that ends the read cycle.

Top module: `txcp_irq_regs`

## Requirements
- R1: After reset, all three status flags, all enables and the discard control are 0, `irq_n` is 1 and `fifo_rst` is 0.
- R2: A pulse on `ev_perr`, `ev_ovr` or `ev_align` sets its status flag at the next clock edge, whatever the enables hold. At local address 6Eh the flags read back in bit 2 (parity), bit 1 (overrun) and bit 0 (alignment change).
- R3: A read of address 6Eh returns the flags and clears all three at the end of that read cycle.
- R4: An event pulse in the same cycle as a clearing read of 6Eh leaves its flag set after that cycle.
- R5: A write to 6Eh stores bit 6 (discard), bit 4 (parity enable), bit 3 (overrun enable) and bit 2 (alignment enable). A read of 6Eh returns bit 6, bit 4 and bit 3 as stored, returns 0 in bits 7 and 5, and returns the flags in bits 2:0, so the alignment enable is write-only.
- R6: A write to 6Eh with bit 7 set makes `fifo_rst` high for exactly the one cycle after the write cycle. Bit 7 always reads back as 0.
- R7: `discard_on_perr` equals the stored bit 6.
- R8: `irq_n` is 0 exactly when some status flag is set and its enable is set. A flag without its enable never pulls `irq_n` low.
- R9: A read of device-level address 05h returns the summary of R8 in bit 3 and 0 in every other bit. The read clears nothing, and writes to 05h change nothing.
- R10: Reads of any other address return 0, and writes to them change no state.
- R11: A status flag stays set over idle cycles until a read of 6Eh clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while `bus_rd` is high |
| ev_perr | input | 1 | Parity error event pulse |
| ev_ovr | input | 1 | FIFO overrun event pulse |
| ev_align | input | 1 | Cell alignment change event pulse |
| fifo_rst | output | 1 | One-cycle FIFO reset pulse |
| discard_on_perr | output | 1 | Discard cells that carry a parity error |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The embedded properties check on every cycle that:
- an event always lands in its flag;
- a flag persists until the local read clears it;
- the FIFO reset pulse only follows a write that asked for it;
- `irq_n` is never low without both a flag and an enable;
- the summary bit read at 05h agrees with `irq_n`.

Some behaviours only the bench's scenarios can show. These are the exact bit positions of the local read image, the write-only alignment enable, and the mapping of each enable to its own source. The bench also covers the event that collides with a clearing read, and the fact that reads of 05h and accesses to other addresses leave the state untouched.

// File: rtl/txcp_irq_pkg.sv
package txcp_irq_pkg;
  localparam int NSRC = 3;
  // source index = position in the status field of the local register
  localparam int SRC_ALIGN = 0;
  localparam int SRC_OVR   = 1;
  localparam int SRC_PERR  = 2;
  // local register control bit positions
  localparam int BIT_FRST     = 7;
  localparam int BIT_DISC     = 6;
  localparam int BIT_EN_LO    = 2;   // enables occupy [BIT_EN_LO +: NSRC]
  localparam int DATA_W       = 8;

  function automatic logic any_enabled(input logic [NSRC-1:0] st,
                                       input logic [NSRC-1:0] en);
    return |(st & en);
  endfunction

  function automatic logic [DATA_W-1:0] local_image(input logic [NSRC-1:0] st,
                                                    input logic [NSRC-1:0] en,
                                                    input logic            disc);
    logic [DATA_W-1:0] img;
    img = '0;
    img[BIT_DISC]          = disc;
    img[BIT_EN_LO+1]       = en[SRC_OVR];
    img[BIT_EN_LO+2]       = en[SRC_PERR];
    img[NSRC-1:0]          = st;   // status overlays the alignment enable
    return img;
  endfunction

  function automatic logic [DATA_W-1:0] top_image(input logic sum, input int pos);
    logic [DATA_W-1:0] img;
    img      = '0;
    img[pos] = sum;
    return img;
  endfunction
endpackage

// File: rtl/txcp_sticky_bits.sv
module txcp_sticky_bits #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         clr,
  output logic [N-1:0] stat
);
  logic [N-1:0] stat_q;

  generate
    for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk) begin
        if (!rst_n) stat_q[i] <= 1'b0;
        else        stat_q[i] <= (stat_q[i] & ~clr) | evt[i];
      end

      AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        evt[i] |=> stat_q[i]);                                  // R2
      AST_COLLIDE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt[i] && clr) |=> stat_q[i]);                         // R4
      AST_HOLD_UNTIL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[i] && !clr) |=> stat_q[i]);                     // R11
      AST_CLR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !evt[i]) |=> !stat_q[i]);                       // R3
    end
  endgenerate

  assign stat = stat_q;
endmodule

// File: rtl/txcp_ctrl_reg.sv
module txcp_ctrl_reg
  import txcp_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wdata,
  output logic [NSRC-1:0]   en,
  output logic              disc,
  output logic              fifo_rst
);
  logic [NSRC-1:0] en_q;
  logic            disc_q;
  logic            frst_q;
  logic            frst_req;

  assign frst_req = wr_hit & wdata[BIT_FRST];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      disc_q <= 1'b0;
      frst_q <= 1'b0;
    end else begin
      frst_q <= frst_req;
      if (wr_hit) begin
        en_q   <= wdata[BIT_EN_LO +: NSRC];
        disc_q <= wdata[BIT_DISC];
      end
    end
  end

  assign en       = en_q;
  assign disc     = disc_q;
  assign fifo_rst = frst_q;

  AST_FRST_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rst |-> $past(frst_req));                              // R6
  AST_FRST_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    frst_req |=> fifo_rst);                                     // R6
  AST_CTRL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> ($stable(en) && $stable(disc)));                // R10
endmodule

// File: rtl/txcp_irq_rollup.sv
module txcp_irq_rollup
  import txcp_irq_pkg::*;
(
  input  logic [NSRC-1:0] stat,
  input  logic [NSRC-1:0] en,
  output logic            summary,
  output logic            irq_n
);
  always_comb begin
    summary = any_enabled(stat, en);
    irq_n   = ~summary;
  end
endmodule

// File: rtl/txcp_irq_regs.sv
module txcp_irq_regs
  import txcp_irq_pkg::*;
#(
  parameter int              ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] LOCAL_ADDR = 8'h6E,
  parameter logic [ADDR_W-1:0] TOP_ADDR   = 8'h05,
  parameter int              TOP_BIT    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              ev_perr,
  input  logic              ev_ovr,
  input  logic              ev_align,
  output logic              fifo_rst,
  output logic              discard_on_perr,
  output logic              irq_n
);
  logic            hit_local;
  logic            hit_top;
  logic            wr_local;
  logic            rd_clear;
  logic [NSRC-1:0] evt;
  logic [NSRC-1:0] stat;
  logic [NSRC-1:0] en;
  logic            disc;
  logic            summary;

  assign hit_local = (bus_addr == LOCAL_ADDR);
  assign hit_top   = (bus_addr == TOP_ADDR);
  assign wr_local  = bus_wr & hit_local;
  assign rd_clear  = bus_rd & hit_local;

  always_comb begin
    evt            = '0;
    evt[SRC_ALIGN] = ev_align;
    evt[SRC_OVR]   = ev_ovr;
    evt[SRC_PERR]  = ev_perr;
  end

  txcp_sticky_bits #(.N(NSRC)) i_sticky (
    .clk  (clk),
    .rst_n(rst_n),
    .evt  (evt),
    .clr  (rd_clear),
    .stat (stat)
  );

  txcp_ctrl_reg i_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_hit  (wr_local),
    .wdata   (bus_wdata),
    .en      (en),
    .disc    (disc),
    .fifo_rst(fifo_rst)
  );

  txcp_irq_rollup i_rollup (
    .stat   (stat),
    .en     (en),
    .summary(summary),
    .irq_n  (irq_n)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (hit_local)    bus_rdata = local_image(stat, en, disc);
      else if (hit_top) bus_rdata = top_image(summary, TOP_BIT);
    end
  end

  assign discard_on_perr = disc;

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> irq_n);                                      // R8
  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (stat != '0));                                   // R8
  AST_TOP_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && hit_top) |-> (bus_rdata[TOP_BIT] == !irq_n));     // R9
  AST_FRST_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> !bus_rdata[BIT_FRST]);                           // R6
  AST_TOP_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !hit_local && stat != '0 && evt == '0) |=> $stable(stat)); // R9
endmodule

// File: tb/test_txcp_irq_regs.sv
module test_txcp_irq_regs;
  localparam int CLK_NS = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       ev_perr = 1'b0;
  logic       ev_ovr = 1'b0;
  logic       ev_align = 1'b0;
  logic       fifo_rst;
  logic       discard_on_perr;
  logic       irq_n;

  always #(CLK_NS/2) clk = ~clk;

  txcp_irq_regs i_txcp_irq_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_perr(ev_perr), .ev_ovr(ev_ovr), .ev_align(ev_align),
    .fifo_rst(fifo_rst), .discard_on_perr(discard_on_perr), .irq_n(irq_n)
  );

  int total = 0;
  int fails = 0;
  bit done = 0;

  // bench model: flags {perr,ovr,align}, enables {perr,ovr,align}, discard
  logic [2:0] m_flag = '0;
  logic [2:0] m_ena  = '0;
  logic       m_disc = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  function automatic logic [7:0] model_read(input logic [7:0] a);
    logic [7:0] v;
    v = 8'h00;
    if (a == 8'h6E) begin
      v[6] = m_disc; v[4] = m_ena[2]; v[3] = m_ena[1]; v[2:0] = m_flag;
    end else if (a == 8'h05) begin
      v[3] = (m_flag[0] & m_ena[0]) | (m_flag[1] & m_ena[1]) | (m_flag[2] & m_ena[2]);
    end
    return v;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // monitor: compares read data mid-cycle against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_NS/4);
      if (bus_rd) begin
        if (exp_q.size() == 0) begin
          total++; fails++;
          $display("FAIL scoreboard: actual %02h expected none", bus_rdata);
        end else begin
          check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
      end
    end
  end

  task automatic bus_read(input logic [7:0] a, input string req, input logic [2:0] evts = 3'b000);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    {ev_perr, ev_ovr, ev_align} = evts;
    exp_q.push_back(model_read(a));
    tag_q.push_back(req);
    @(negedge clk);
    bus_rd = 1'b0;
    {ev_perr, ev_ovr, ev_align} = 3'b000;
    if (a == 8'h6E) m_flag = 3'b000;
    m_flag = m_flag | evts;
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a == 8'h6E) begin
      m_ena = d[4:2]; m_disc = d[6];
    end
  endtask

  task automatic pulse(input logic [2:0] evts);
    @(negedge clk);
    {ev_perr, ev_ovr, ev_align} = evts;
    @(negedge clk);
    {ev_perr, ev_ovr, ev_align} = 3'b000;
    m_flag = m_flag | evts;
  endtask

  task automatic check_irq(input string req);
    #(CLK_NS/4);
    check(req, {7'b0, irq_n}, {7'b0, ~|(m_flag & m_ena)});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #(CLK_NS/4);
    check("R1 irq_n", {7'b0, irq_n}, 8'h01);
    check("R1 fifo_rst", {7'b0, fifo_rst}, 8'h00);
    check("R1 discard", {7'b0, discard_on_perr}, 8'h00);
    bus_read(8'h6E, "R1 local");
    bus_read(8'h05, "R1 top");

    // R2 / R3: parity flag, then read clears it
    pulse(3'b100);
    bus_read(8'h6E, "R2 parity flag");
    bus_read(8'h6E, "R3 cleared after read");

    // R11: flags survive idle cycles
    pulse(3'b010);
    pulse(3'b001);
    repeat (4) @(negedge clk);
    bus_read(8'h6E, "R11 flags held");

    // R5 / R7: write image, alignment enable is write-only
    bus_write(8'h6E, 8'h5C);
    bus_read(8'h6E, "R5 image");
    #(CLK_NS/4);
    check("R7 discard", {7'b0, discard_on_perr}, 8'h01);

    // R8 / R9: enabled source raises irq, top read does not clear
    pulse(3'b001);
    check_irq("R8 align enabled");
    bus_read(8'h05, "R9 top summary");
    bus_read(8'h05, "R9 top read no clear");
    bus_read(8'h6E, "R3 read with flag");
    check_irq("R8 cleared");

    // R8 enable mapping: only parity enabled
    bus_write(8'h6E, 8'h10);
    pulse(3'b010);
    check_irq("R8 overrun masked");
    bus_read(8'h05, "R9 masked summary");
    pulse(3'b100);
    check_irq("R8 parity enabled");
    bus_read(8'h6E, "R3 clear both");

    // R8: alignment enable alone (bit 2)
    bus_write(8'h6E, 8'h04);
    pulse(3'b100);
    check_irq("R8 parity masked by align-only");
    pulse(3'b001);
    check_irq("R8 align-only enabled");
    bus_read(8'h6E, "R3 clear");

    // R4: event collides with clearing read
    bus_read(8'h6E, "R4 read during event", 3'b010);
    bus_read(8'h6E, "R4 flag kept");

    // R6: FIFO reset pulse
    bus_write(8'h6E, 8'h80);
    #(CLK_NS/4);
    check("R6 pulse high", {7'b0, fifo_rst}, 8'h01);
    @(negedge clk);
    #(CLK_NS/4);
    check("R6 pulse one cycle", {7'b0, fifo_rst}, 8'h00);
    bus_read(8'h6E, "R6 bit7 reads 0");
    check("R7 discard cleared", {7'b0, discard_on_perr}, 8'h00);

    // R10 / R9: other addresses and writes to 05h
    bus_write(8'h6E, 8'h18);
    bus_write(8'h33, 8'hFF);
    bus_write(8'h05, 8'hFF);
    bus_read(8'h6E, "R10 unchanged by other writes");
    bus_read(8'h33, "R10 other read zero");
    pulse(3'b010);
    bus_read(8'h05, "R9 write ignored");
    bus_read(8'h7F, "R10 other read zero with flag");
    bus_read(8'h6E, "R10 flag survived other read");

    repeat (2) @(negedge clk);
    check("scoreboard drained", 8'(exp_q.size()), 8'h00);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(CLK_NS * 20000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule